// File: doc/BRIEF.md
# Translation Buffer Victim Selector and Writer

This block owns the storage of a fully associative translation buffer: 64 slots, each holding a 64-bit tag and a 64-bit translation word. Software or a refill engine hands it a new tag and translation. For an automatic insert, the block chooses the slot to overwrite from three status bits kept in each translation word. Bit 63 marks the slot valid, bit 6 marks it locked, and bit 41 records recent use. A second request kind, the direct write, overwrites the slot named by the request address. It ignores the status bits.

Automatic victim choice has three tiers. An empty slot is taken first. Failing that, the block takes a slot that is neither pinned nor recently used. If no such slot exists, the block forgets all recent-use history in one sweep and searches once more. A buffer that holds only pinned slots refuses the insert.

When a valid translation is displaced, the block reports the old page range so that downstream copies can be discarded. Lookup logic outside the block marks slots as used through a touch input. A combinational read port exposes every slot.

A touch is applied before a used-bit sweep, and a write takes precedence over both in the same cycle.

Top module: `tlb_victim_writer`

## Requirements
- R1: After reset, every slot reads back tag 0 and translation 0, `req_ready` is high, and `done`, `fail` and `flush_valid` are low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only then does `req_ready` drop. It stays low until the cycle after the request ends. Each request ends with exactly one cycle in which exactly one of `done` or `fail` is high. That cycle is the first cycle after acceptance, or the second cycle when a used-bit sweep is needed.
- R3: An automatic insert (`req_direct`=0) writes the new tag and translation into the lowest-indexed slot whose translation bit 63 is 0.
- R4: When all slots have bit 63 set, an automatic insert writes the lowest-indexed slot whose bit 6 (locked) and bit 41 (used) are both 0.
- R5: When no slot qualifies under R4, the first cycle after acceptance clears bit 41 in all 64 slots and raises neither `done` nor `fail`. The R4 search is then repeated, and `done` follows in the next cycle.
- R6: When the repeated search also finds no slot, `fail` is raised, no slot's tag or translation is written, and every slot is left with bit 41 clear.
- R7: A direct write (`req_direct`=1) replaces the slot whose index is `req_addr[8:3]`, whatever that slot's valid, locked or used bits hold.
- R8: When the slot written held a translation with bit 63 set, `flush_valid` is high in the `done` cycle. In that cycle `flush_mask` equals 64'hFFFF_FFFF_FFFF_E000 shifted left by 3 times the old translation's bits [62:61], and `flush_va` equals the old tag ANDed with `flush_mask`. Otherwise `flush_valid` stays low.
- R9: A `touch_valid` pulse sets bit 41 of slot `touch_idx` at the next clock edge. `rd_tag` and `rd_tte` show slot `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_direct | input | 1 | 1 = direct-indexed write, 0 = automatic insert |
| req_addr | input | 64 | Access address; bits [8:3] select the slot for a direct write |
| req_tag | input | 64 | Tag to store |
| req_tte | input | 64 | Translation word to store |
| req_ready | output | 1 | High when a request can be taken |
| done | output | 1 | One-cycle pulse: slot written |
| fail | output | 1 | One-cycle pulse: insert refused, nothing written |
| flush_valid | output | 1 | Displaced translation was valid; flush its range |
| flush_va | output | 64 | Base of the displaced page range |
| flush_mask | output | 64 | Address mask of the displaced page range |
| touch_valid | input | 1 | Mark a slot as recently used |
| touch_idx | input | 6 | Slot to mark |
| rd_idx | input | 6 | Slot to read |
| rd_tag | output | 64 | Tag of slot `rd_idx` |
| rd_tte | output | 64 | Translation word of slot `rd_idx` |

## Verification
The hardest states to reach from the ports are the sweep-and-retry path and the refusal path. Both need all 64 slots valid, and every unpinned slot marked used, before the insert arrives. To get there, the bench fills the buffer with automatic inserts and then touches each unpinned slot one by one, which forces the two-cycle completion. For refusal, the bench pins every slot with a series of direct writes and touches a few of them. It then confirms that the sweep ran, that `fail` came in the second cycle, and that no tag or translation changed.

// File: rtl/tlb_victim_writer.sv
module tlb_victim_writer #(
  parameter int ENTRIES    = 64,
  parameter int DW         = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_LSB    = 3,
  parameter int IW         = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_direct,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_tag,
  input  logic [DW-1:0] req_tte,
  output logic          req_ready,
  output logic          done,
  output logic          fail,
  output logic          flush_valid,
  output logic [DW-1:0] flush_va,
  output logic [DW-1:0] flush_mask,
  input  logic          touch_valid,
  input  logic [IW-1:0] touch_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_tag,
  output logic [DW-1:0] rd_tte
);
  localparam int VB = 63;
  localparam int UB = 41;
  localparam int LB = 6;
  localparam int SZ = 61;

  logic [DW-1:0] tag_q [ENTRIES];
  logic [DW-1:0] tte_q [ENTRIES];

  logic          busy, swept, direct_q;
  logic [DW-1:0] addr_q, ntag_q, ntte_q;

  logic          inv_hit, free_hit, used_any;
  logic [IW-1:0] inv_idx, free_idx, victim;
  logic          found, do_sweep;
  logic [DW-1:0] old_tte;
  logic [7:0]    shamt;

  always_comb begin
    inv_hit  = 1'b0;
    inv_idx  = '0;
    free_hit = 1'b0;
    free_idx = '0;
    used_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!tte_q[i][VB]) begin
        inv_hit = 1'b1;
        inv_idx = IW'(i);
      end
      if (!tte_q[i][LB] && !tte_q[i][UB]) begin
        free_hit = 1'b1;
        free_idx = IW'(i);
      end
      used_any = used_any | tte_q[i][UB];
    end
  end

  assign victim   = direct_q ? addr_q[IDX_LSB +: IW] : (inv_hit ? inv_idx : free_idx);
  assign found    = direct_q | inv_hit | free_hit;
  assign done     = busy & found;
  assign fail     = busy & ~found & swept;
  assign do_sweep = busy & ~found & ~swept;
  assign req_ready = ~busy;

  assign old_tte     = tte_q[victim];
  assign shamt       = 8'(PAGE_SHIFT) + 8'd3 * {6'd0, old_tte[SZ +: 2]};
  assign flush_mask  = {DW{1'b1}} << shamt;
  assign flush_va    = tag_q[victim] & flush_mask;
  assign flush_valid = done & old_tte[VB];

  assign rd_tag = tag_q[rd_idx];
  assign rd_tte = tte_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      swept    <= 1'b0;
      direct_q <= 1'b0;
      addr_q   <= '0;
      ntag_q   <= '0;
      ntte_q   <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy     <= 1'b1;
        swept    <= 1'b0;
        direct_q <= req_direct;
        addr_q   <= req_addr;
        ntag_q   <= req_tag;
        ntte_q   <= req_tte;
      end
    end else if (done || fail) begin
      busy <= 1'b0;
    end else if (do_sweep) begin
      swept <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end else begin
        if (touch_valid && touch_idx == IW'(i)) tte_q[i][UB] <= 1'b1;
        if (do_sweep) tte_q[i][UB] <= 1'b0;
        if (done && victim == IW'(i)) begin
          tag_q[i] <= ntag_q;
          tte_q[i] <= ntte_q;
        end
      end
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> req_ready);

  // R2
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R5
  sweep_then_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_sweep |=> (done || fail));

  // R6
  fail_used_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !used_any);

  // R8
  flush_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> done);

  // R9
  touch_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && !busy) |=> tte_q[$past(touch_idx)][UB]);
endmodule

// File: tb/tlb_victim_writer_bench.sv
module tlb_victim_writer_bench;
  localparam logic [63:0] V = 64'h1 << 63;
  localparam logic [63:0] U = 64'h1 << 41;
  localparam logic [63:0] L = 64'h1 << 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_direct = 1'b0;
  logic [63:0] req_addr = '0, req_tag = '0, req_tte = '0;
  logic        req_ready, done, fail, flush_valid;
  logic [63:0] flush_va, flush_mask, rd_tag, rd_tte;
  logic        touch_valid = 1'b0;
  logic [5:0]  touch_idx = '0, rd_idx = '0;

  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  int checks = 0, errors = 0;
  bit in_req = 1'b0, finished = 1'b0;

  always #2 clk = ~clk;

  tlb_victim_writer u_tlb_victim_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_direct(req_direct),
    .req_addr(req_addr), .req_tag(req_tag), .req_tte(req_tte),
    .req_ready(req_ready), .done(done), .fail(fail),
    .flush_valid(flush_valid), .flush_va(flush_va), .flush_mask(flush_mask),
    .touch_valid(touch_valid), .touch_idx(touch_idx),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_tte(rd_tte));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // R1 R2: idle outputs compared every clock outside requests
  always @(negedge clk) begin
    if (rst_n && !in_req && !finished) begin
      chk(req_ready && !done && !fail && !flush_valid, "R2 idle outputs",
          {60'd0, req_ready, done, fail, flush_valid}, 64'h8);
    end
  end

  function automatic logic [63:0] mk(input bit lk, input int sz, input logic [63:0] extra);
    return V | (lk ? L : 64'h0) | (64'(sz & 3) << 61) | extra;
  endfunction

  task automatic scan(input string rq);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      @(negedge clk);
      if (rd_tag !== m_tag[i] || rd_tte !== m_tte[i]) begin
        bad++;
        $display("FAIL %s slot %0d actual=%h/%h expected=%h/%h", rq, i, rd_tag, rd_tte, m_tag[i], m_tte[i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic touch(input int idx);
    touch_valid = 1'b1;
    touch_idx = 6'(idx);
    @(negedge clk);
    touch_valid = 1'b0;
    m_tte[idx] = m_tte[idx] | U;
  endtask

  task automatic issue(input bit direct, input logic [63:0] addr, input logic [63:0] tag,
                       input logic [63:0] tte, input int want_idx, input string rq);
    int idx = -1;
    bit sweep = 1'b0, fl = 1'b0;
    logic [63:0] mask = '0, va = '0;
    if (direct) idx = int'(addr[8:3]);
    else begin
      for (int i = 0; i < 64; i++) if (!m_tte[i][63]) begin idx = i; break; end
      if (idx < 0)
        for (int i = 0; i < 64; i++) if (!m_tte[i][6] && !m_tte[i][41]) begin idx = i; break; end
      if (idx < 0) begin
        sweep = 1'b1;
        for (int i = 0; i < 64; i++) m_tte[i][41] = 1'b0;
        for (int i = 0; i < 64; i++) if (!m_tte[i][6] && !m_tte[i][41]) begin idx = i; break; end
      end
    end
    if (want_idx != -2) chk(idx == want_idx, {rq, " model victim"}, 64'(idx), 64'(want_idx));
    if (idx >= 0 && m_tte[idx][63]) begin
      fl = 1'b1;
      mask = 64'hFFFF_FFFF_FFFF_E000 << (3 * int'(m_tte[idx][62:61]));
      va = m_tag[idx] & mask;
    end
    in_req = 1'b1;
    req_valid = 1'b1; req_direct = direct; req_addr = addr; req_tag = tag; req_tte = tte;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    if (sweep) begin
      chk(!done && !fail && !req_ready, "R5 sweep cycle quiet", {61'd0, done, fail, req_ready}, 64'h0);
      @(negedge clk);
    end
    chk(done == (idx >= 0), {rq, " R2 done"}, 64'(done), 64'(idx >= 0));
    chk(fail == (idx < 0), {rq, " R6 fail"}, 64'(fail), 64'(idx < 0));
    chk(!req_ready, "R2 ready low while busy", 64'(req_ready), 64'h0);
    chk(flush_valid == fl, {rq, " R8 flush_valid"}, 64'(flush_valid), 64'(fl));
    if (fl) begin
      chk(flush_mask == mask, "R8 flush_mask", flush_mask, mask);
      chk(flush_va == va, "R8 flush_va", flush_va, va);
    end
    if (idx >= 0) begin
      m_tag[idx] = tag;
      m_tte[idx] = tte;
    end
    @(negedge clk);
    chk(req_ready && !done && !fail, "R2 single pulse then ready", {61'd0, req_ready, done, fail}, 64'h4);
    in_req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !fail && !flush_valid, "R1 reset outputs",
        {60'd0, req_ready, done, fail, flush_valid}, 64'h8);
    scan("R1 R9 reset contents");

    // R3: fill empty buffer in index order; slots 0,1,2,10 pinned
    for (int k = 0; k < 64; k++)
      issue(1'b0, '0, 64'h0000_7000_0000_0000 | (64'(k) << 20) | 64'(k * 7),
            mk(k < 3 || k == 10, k, 64'(k)), k, "R3 fill");
    scan("R3 after fill");

    // R4 R8: all valid, nothing used -> first unpinned
    issue(1'b0, '0, 64'hDEAD_BEEF_0000_1234, mk(0, 2, 64'h0), 3, "R4 first unpinned");
    touch(3); touch(4); touch(5);
    issue(1'b0, '0, 64'hCAFE_0000_0000_5678, mk(0, 1, 64'h0), 6, "R4 R9 skip used");
    scan("R4 R9 contents");

    // R5: every unpinned slot used -> sweep then retry
    for (int k = 0; k < 64; k++) if (!(k < 3 || k == 10) && !m_tte[k][41]) touch(k);
    issue(1'b0, '0, 64'h1111_2222_3333_4444, mk(0, 3, 64'h0), 3, "R5 sweep retry");
    scan("R5 used bits swept");

    // R7: direct write to a pinned slot
    issue(1'b1, 64'hABC0_0000_0000_0050, 64'h5555_0000_0000_AAAA, mk(1, 3, 64'h0), 10, "R7 direct pinned");
    // R7 then R3: invalidate slot 20 directly, insert lands there
    issue(1'b1, 64'h0000_0000_0000_00A7, 64'h0, 64'h0, 20, "R7 direct invalidate");
    issue(1'b0, '0, 64'h7777_0000_0000_0001, mk(0, 0, 64'h0), 20, "R3 reuse invalid");
    scan("R7 R3 contents");

    // R6: pin everything, mark some used, insert must fail
    for (int k = 0; k < 64; k++)
      issue(1'b1, 64'(k) << 3, 64'h9000_0000_0000_0000 | 64'(k), mk(1, k + 1, 64'h0), k, "R7 pin all");
    touch(0); touch(17); touch(63);
    issue(1'b0, '0, 64'hFFFF_0000_0000_FFFF, mk(0, 0, 64'h0), -1, "R6 all pinned");
    scan("R6 nothing written, used clear");

    // R4: unpin slot 7 directly, insert takes it
    issue(1'b1, 64'h38, 64'h8888_0000_0000_0007, mk(0, 2, 64'h0), 7, "R7 unpin");
    issue(1'b0, '0, 64'h4444_0000_0000_0004, mk(0, 1, 64'h0), 7, "R4 after unpin");
    scan("R4 final contents");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule